// File: doc/BRIEF.md
# Switching-Aware Probabilistic Bus Saboteur

This block sits inline on a group of parallel bus lines and corrupts them on purpose, so that a system model can be exercised under timing faults like those seen at very low supply voltage. Each line keeps a register of the value it carried on the previous clock. A detector sorts every line, every cycle, into rising, falling or holding. A line can only fail on a cycle where it switches. When it fails, the output keeps showing the old value, as if the new level had not reached the sampling point in time.

The fault decision compares a pseudo-random 16-bit number against a threshold. There is one threshold for 0-to-1 edges and another for 1-to-0 edges, each a fraction of full scale (threshold / 65536). A 32-bit maximal-length LFSR supplies the random bits. Each line reads its own rotated 16-bit window of the LFSR state, so that the lines fail largely independently. With the enable low the block is a plain wire bundle. The clean history is updated whether or not the block is enabled.

Top module: `edge_saboteur`

## Requirements
- R1: While `en_i` is low, `bus_o` equals `bus_i` on every line in the same cycle.
- R2: A line whose input equals its stored previous value (a holding line) is never corrupted, whatever the thresholds are.
- R3: A line switching 0 to 1 is corrupted exactly when its random number is strictly less than `thr_rise_i`.
- R4: A line switching 1 to 0 is corrupted exactly when its random number is strictly less than `thr_fall_i`.
- R5: A corrupted line drives its previous input value, which is the complement of its current input. The stored history is updated at each clock with the clean input, whether or not the line was corrupted and whether or not the block is enabled.
- R6: Asynchronous active-low reset clears every stored previous value to 0 and loads the LFSR with `seed_i`. A zero seed is replaced by 1.
- R7: The LFSR shifts right once per clock out of reset. When the bit shifted out is 1, the mask 0x80200003 is XORed in. The random number of line i is formed from the current state, with its bit j taken from state bit (7*i + j) mod 32.
- R8: A threshold of 0 never corrupts. A threshold of 0xFFFF corrupts every edge of that direction, except when the random number is 0xFFFF.
- R9: Over 100k transitions with the 10% rise / 5% fall setting (6554 / 3277), the observed fault rate of each direction lies within 15% of its threshold / 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Fault injection enable |
| seed_i | input | 32 | LFSR seed loaded during reset |
| thr_rise_i | input | 16 | Failure threshold for 0-to-1 edges |
| thr_fall_i | input | 16 | Failure threshold for 1-to-0 edges |
| bus_i | input | LINES (8) | Clean bus from the driver |
| bus_o | output | LINES (8) | Sabotaged bus to the receiver |

## Verification
Holding patterns with both thresholds at full scale show that only edges can fail. Alternating all-zeros and all-ones patterns under split thresholds (full scale for rising, zero for falling) show that each edge direction uses its own threshold. Random bus words under the 5%/3% setting are checked bit for bit against an independent LFSR model, which exposes any error in window selection, compare direction or history update. A long alternating run at 10%/5% checks the statistical rates, and a run started from a zero seed checks the seed substitution.

// File: rtl/sab_pkg.sv
package sab_pkg;

    localparam int LFSR_W = 32;
    localparam logic [LFSR_W-1:0] LFSR_MASK = 32'h8020_0003;

    typedef enum logic [1:0] {
        SW_HOLD = 2'd0,
        SW_RISE = 2'd1,
        SW_FALL = 2'd2
    } sw_kind_e;

    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ LFSR_MASK;
        return n;
    endfunction

endpackage

// File: rtl/sab_lfsr.sv
module sab_lfsr #(
    parameter int W = sab_pkg::LFSR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] state_o
);
    typedef struct packed {
        logic [W-1:0] state;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;
    logic [W-1:0] seed_safe;

    always_comb begin
        seed_safe = (seed_i == '0) ? W'(1) : seed_i;
        st_d = st_q;
        st_d.state = sab_pkg::lfsr_advance(st_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.state <= seed_safe;
        else        st_q <= st_d;
    end

    assign state_o = st_q.state;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state != '0); // R6
    AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.state != $past(st_q.state)); // R7
endmodule

// File: rtl/sab_edge_det.sv
module sab_edge_det #(
    parameter int LINES = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [LINES-1:0]                  bus_i,
    output logic [LINES-1:0]                  hist_o,
    output sab_pkg::sw_kind_e [LINES-1:0]     kind_o
);
    typedef struct packed {
        logic [LINES-1:0] hist;
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.hist = bus_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_cls
        always_comb begin
            if (bus_i[i] == st_q.hist[i]) kind_o[i] = sab_pkg::SW_HOLD;
            else if (bus_i[i])            kind_o[i] = sab_pkg::SW_RISE;
            else                          kind_o[i] = sab_pkg::SW_FALL;
        end
    end

    assign hist_o = st_q.hist;
endmodule

// File: rtl/sab_fault_gate.sv
module sab_fault_gate #(
    parameter int LINES  = 8,
    parameter int RND_W  = 16,
    parameter int STRIDE = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_i,
    input  logic [RND_W-1:0]              thr_rise_i,
    input  logic [RND_W-1:0]              thr_fall_i,
    input  logic [sab_pkg::LFSR_W-1:0]    lfsr_i,
    input  logic [LINES-1:0]              hist_i,
    input  sab_pkg::sw_kind_e [LINES-1:0] kind_i,
    input  logic [LINES-1:0]              bus_i,
    output logic [LINES-1:0]              bus_o
);
    localparam int LW = sab_pkg::LFSR_W;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [RND_W-1:0] rnd;
        logic             hit;

        always_comb begin
            for (int j = 0; j < RND_W; j++) begin
                rnd[j] = lfsr_i[(i*STRIDE + j) % LW];
            end
        end

        always_comb begin
            unique case (kind_i[i])
                sab_pkg::SW_RISE: hit = en_i && (rnd < thr_rise_i);
                sab_pkg::SW_FALL: hit = en_i && (rnd < thr_fall_i);
                default:          hit = 1'b0;
            endcase
            bus_o[i] = hit ? hist_i[i] : bus_i[i];
        end

        AST_STATIC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            kind_i[i] == sab_pkg::SW_HOLD |-> bus_o[i] == bus_i[i]); // R2
        AST_RISE_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
            (kind_i[i] == sab_pkg::SW_RISE && bus_o[i] != bus_i[i]) |-> rnd < thr_rise_i); // R3
        AST_FALL_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
            (kind_i[i] == sab_pkg::SW_FALL && bus_o[i] != bus_i[i]) |-> rnd < thr_fall_i); // R4
        AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            bus_o[i] != bus_i[i] |-> bus_o[i] == hist_i[i]); // R5
    end

    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> bus_o == bus_i); // R1
endmodule

// File: rtl/edge_saboteur.sv
module edge_saboteur #(
    parameter int LINES  = 8,
    parameter int RND_W  = 16,
    parameter int STRIDE = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic [31:0]                seed_i,
    input  logic [RND_W-1:0]           thr_rise_i,
    input  logic [RND_W-1:0]           thr_fall_i,
    input  logic [LINES-1:0]           bus_i,
    output logic [LINES-1:0]           bus_o
);
    localparam int LW = sab_pkg::LFSR_W;

    logic [LW-1:0]                  lfsr;
    logic [LINES-1:0]               hist;
    sab_pkg::sw_kind_e [LINES-1:0]  kind;

    sab_lfsr #(.W(LW)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_i  (seed_i),
        .state_o (lfsr)
    );

    sab_edge_det #(.LINES(LINES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_i  (bus_i),
        .hist_o (hist),
        .kind_o (kind)
    );

    sab_fault_gate #(.LINES(LINES), .RND_W(RND_W), .STRIDE(STRIDE)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .thr_rise_i (thr_rise_i),
        .thr_fall_i (thr_fall_i),
        .lfsr_i     (lfsr),
        .hist_i     (hist),
        .kind_i     (kind),
        .bus_i      (bus_i),
        .bus_o      (bus_o)
    );
endmodule

// File: tb/edge_saboteur_bench.sv
module edge_saboteur_bench;
    localparam int N = 8;
    localparam logic [31:0] MASK = 32'h8020_0003;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b1;
    logic [31:0]  seed = 32'h1;
    logic [15:0]  tr = '0, tf = '0;
    logic [N-1:0] din = '0;
    logic [N-1:0] dout;

    int total = 0, bad = 0;
    bit finished = 0;
    int rise_n = 0, rise_f = 0, fall_n = 0, fall_f = 0;

    logic [31:0]  m_lfsr;
    logic [N-1:0] m_prev;

    always #4 clk = ~clk;

    edge_saboteur u_edge_saboteur (
        .clk(clk), .rst_n(rst_n), .en_i(en), .seed_i(seed),
        .thr_rise_i(tr), .thr_fall_i(tf), .bus_i(din), .bus_o(dout)
    );

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ MASK) : (s >> 1);
    endfunction

    function automatic logic [15:0] m_rnd(input logic [31:0] s, input int line);
        logic [15:0] r;
        for (int j = 0; j < 16; j++) r[j] = s[(line*7 + j) % 32];
        return r;
    endfunction

    function automatic logic [N-1:0] m_expect(input logic [N-1:0] v);
        logic [N-1:0] o;
        o = v;
        for (int i = 0; i < N; i++) begin
            if (en && !m_prev[i] && v[i] && m_rnd(m_lfsr, i) < tr) o[i] = m_prev[i];
            if (en && m_prev[i] && !v[i] && m_rnd(m_lfsr, i) < tf) o[i] = m_prev[i];
        end
        return o;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic cyc(input logic [N-1:0] v, input string tag);
        logic [N-1:0] exp_o;
        din = v;
        #1;
        exp_o = m_expect(v);
        total++;
        if (dout !== exp_o) begin
            bad++;
            $display("FAIL %s: out=%h expected=%h in=%h", tag, dout, exp_o, v);
        end
        for (int i = 0; i < N; i++) begin
            if (en && !m_prev[i] && v[i]) begin rise_n++; if (dout[i] != v[i]) rise_f++; end
            if (en && m_prev[i] && !v[i]) begin fall_n++; if (dout[i] != v[i]) fall_f++; end
        end
        @(posedge clk);
        m_prev = v;
        m_lfsr = m_step(m_lfsr);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [31:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        seed = s;
        din = '0;
        repeat (2) @(negedge clk);
        m_lfsr = (s == 0) ? 32'h1 : s;
        m_prev = '0;
        rst_n = 1'b1;
    endtask

    task automatic rate_check(input int n, input int f, input logic [15:0] thr, input string tag);
        real e, d;
        e = real'(n) * real'(thr) / 65536.0;
        d = real'(f) - e;
        if (d < 0.0) d = -d;
        total++;
        if (d > 0.15 * e) begin
            bad++;
            $display("FAIL %s: faults=%0d expected=%0.1f over %0d edges", tag, f, e, n);
        end
    endtask

    initial begin
        int r;
        r = $urandom(32'd20240611);
        do_reset(32'hACE1_2468);

        // R6: history cleared -> all-ones input is a rising edge on every line
        tr = 16'hFFFF; tf = 16'hFFFF;
        cyc('0, "R6");
        cyc('1, "R6");

        // R1: disabled -> pure passthrough despite full-scale thresholds
        en = 1'b0;
        for (int k = 0; k < 60; k++) cyc(N'($urandom), "R1");
        en = 1'b1;

        // R2: holding lines never corrupted
        for (int k = 0; k < 20; k++) cyc(8'hA5, "R2");
        for (int k = 0; k < 20; k++) cyc(8'h00, "R2");

        // R8: zero thresholds never corrupt
        tr = 16'h0000; tf = 16'h0000;
        for (int k = 0; k < 60; k++) cyc((k % 2) ? '1 : '0, "R8");

        // R3 / R4 / R8: split thresholds pick the direction
        tr = 16'hFFFF; tf = 16'h0000;
        for (int k = 0; k < 60; k++) cyc((k % 2) ? '1 : '0, "R3");
        tr = 16'h0000; tf = 16'hFFFF;
        for (int k = 0; k < 60; k++) cyc((k % 2) ? '1 : '0, "R4");

        // R5 / R7: random words at 5% rise / 3% fall, exact model match
        tr = 16'd3277; tf = 16'd1966;
        for (int k = 0; k < 2000; k++) cyc(N'($urandom), "R7");
        // R5: enable toggled mid-stream, history keeps tracking input
        for (int k = 0; k < 200; k++) begin
            en = (($urandom % 3) != 0);
            cyc(N'($urandom), "R5");
        end
        en = 1'b1;

        // R9: statistical rate at 10% rise / 5% fall over 100k edges
        tr = 16'd6554; tf = 16'd3277;
        rise_n = 0; rise_f = 0; fall_n = 0; fall_f = 0;
        for (int k = 0; k < 12500; k++) cyc((k % 2) ? '0 : '1, "R9");
        rate_check(rise_n, rise_f, tr, "R9 rise");
        rate_check(fall_n, fall_f, tf, "R9 fall");

        // R6: zero seed replaced by 1
        do_reset(32'h0);
        tr = 16'd6554; tf = 16'd3277;
        for (int k = 0; k < 300; k++) cyc(N'($urandom), "R6 zero-seed");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog (all requirements): actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule